// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address for 4 KB pages. It reads a two-level translation table that lives in memory. A request picks one of two first-level table bases, one for the kernel address space and one for the user address space. The block reads the first-level entry and takes the second-level table base from that entry. It then reads the second-level entry and joins the frame number from that entry with the page offset of the request.

No register holds a second-level table base. That base only ever comes from the first-level entry that was just fetched. If either entry is marked invalid, the walk ends with a fault response that names the level which failed.

The block serves one walk at a time. It has a valid/ready request port, a valid/ready response port, and a memory read port that allows only one read in flight. The two base registers are written through a small write port, and each walk samples its base at the cycle the request is accepted.

Top module: `pagewalk_unit`

## Requirements
- R1: After reset, req_ready is 1, and rsp_valid and mem_req are both 0.
- R2: A request with req_space 0 walks from base register 0, and one with req_space 1 walks from base register 1. base_wr_en with base_wr_sel writes base_wr_data into the chosen register.
- R3: The first memory read is at the address {base[31:14], va[31:20], 2'b00}. Bits 13:0 of the base register are ignored.
- R4: The second memory read is at {d1[31:10], va[19:12], 2'b00}, where d1 is the first-level entry. Bits 9:0 of d1, apart from the validity code, do not affect the address.
- R5: When both entries are valid, the response has rsp_fault 0 and rsp_paddr = {d2[31:12], va[11:0]}, where d2 is the second-level entry.
- R6: A first-level entry with bits [1:0] = 2'b00 gives a response with rsp_fault 1, rsp_fault_lvl 0 and rsp_paddr 0, and no second memory read is made.
- R7: A second-level entry with bits [1:0] = 2'b00 gives a response with rsp_fault 1, rsp_fault_lvl 1 and rsp_paddr 0.
- R8: While mem_gnt is low, mem_req stays high and mem_rd_addr does not change. After a grant, no new mem_req is raised until mem_rvalid has returned the data.
- R9: req_ready is high only while no walk is in progress. A response holds rsp_valid, rsp_paddr, rsp_fault and rsp_fault_lvl steady until it is taken with rsp_ready.
- R10: Writing a base register while a walk is running does not change that walk. The next request sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_wr_en | input | 1 | Base register write strobe |
| base_wr_sel | input | 1 | Base register to write (0 = kernel, 1 = user) |
| base_wr_data | input | 32 | First-level table base to store |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_space | input | 1 | Base register to walk from |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_fault | output | 1 | Walk hit an invalid entry |
| rsp_fault_lvl | output | 1 | Failing level (0 = first, 1 = second) |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| mem_req | output | 1 | Memory read request |
| mem_gnt | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Memory read byte address |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Returned table entry |

## Verification
The first read address appears on mem_rd_addr one cycle after the request is accepted. It then stays there until the grant. The second read address appears one cycle after the first mem_rvalid. The response is raised one cycle after the mem_rvalid that ends the walk, whether the walk completes or faults. Because these delays depend on the memory model's grant and data delays, the bench does not count fixed cycles. Instead, its memory model compares each read address with the queued expectation at the moment it grants. The response monitor samples on falling edges whenever rsp_valid is high, and stalls rsp_ready for a varying number of cycles to show that the result holds until it is taken.

// File: rtl/pagewalk_pkg.sv
package pagewalk_pkg;

  localparam int unsigned PW_AW      = 32;
  localparam int unsigned PW_PAGE_W  = 12;
  localparam int unsigned PW_L2IDX_W = 8;
  localparam int unsigned PW_DESC_LG = 2;
  localparam int unsigned PW_L1IDX_W = PW_AW - PW_PAGE_W - PW_L2IDX_W;
  localparam int unsigned PW_L1_ALN  = PW_L1IDX_W + PW_DESC_LG;
  localparam int unsigned PW_L2_ALN  = PW_L2IDX_W + PW_DESC_LG;

  typedef logic [PW_AW-1:0] pw_addr_t;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_L1_REQ,
    WS_L1_WAIT,
    WS_L2_REQ,
    WS_L2_WAIT,
    WS_DONE,
    WS_FAULT
  } walk_state_e;

  function automatic pw_addr_t l1_entry_addr(input pw_addr_t base, input pw_addr_t va);
    return {base[PW_AW-1:PW_L1_ALN], va[PW_AW-1:PW_AW-PW_L1IDX_W], {PW_DESC_LG{1'b0}}};
  endfunction

  function automatic pw_addr_t l2_entry_addr(input pw_addr_t d1, input pw_addr_t va);
    return {d1[PW_AW-1:PW_L2_ALN], va[PW_PAGE_W+PW_L2IDX_W-1:PW_PAGE_W], {PW_DESC_LG{1'b0}}};
  endfunction

  function automatic pw_addr_t page_phys(input pw_addr_t d2, input pw_addr_t va);
    return {d2[PW_AW-1:PW_PAGE_W], va[PW_PAGE_W-1:0]};
  endfunction

  function automatic logic entry_ok(input pw_addr_t d);
    return d[1:0] != 2'b00;
  endfunction

endpackage

// File: rtl/pagewalk_basebank.sv
module pagewalk_basebank
  import pagewalk_pkg::*;
#(
  parameter int unsigned NUM_BASE = 2,
  localparam int unsigned SEL_W = (NUM_BASE > 1) ? $clog2(NUM_BASE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  pw_addr_t         wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output pw_addr_t         rd_base
);

  pw_addr_t base_q [NUM_BASE];

  for (genvar g = 0; g < NUM_BASE; g++) begin : g_base
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g] <= '0;
      end else if (wr_en && (wr_sel == SEL_W'(g))) begin
        base_q[g] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_base = base_q[0];
    for (int i = 0; i < NUM_BASE; i++) begin
      if (rd_sel == SEL_W'(i)) rd_base = base_q[i];
    end
  end

endmodule

// File: rtl/pagewalk_ctrl.sv
module pagewalk_ctrl
  import pagewalk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  output logic     req_ready,
  input  logic     mem_gnt,
  input  logic     mem_rvalid,
  input  pw_addr_t mem_rdata,
  output logic     mem_req,
  output logic     phase_l2,
  input  logic     rsp_ready,
  output logic     rsp_valid,
  output logic     rsp_fault,
  output logic     rsp_fault_lvl,
  output logic     walk_start,
  output logic     l1_take,
  output logic     l2_take,
  output logic     fault_take
);

  walk_state_e state_q, state_d;
  logic        lvl_q, lvl_d;
  logic        data_ok;

  assign data_ok = entry_ok(mem_rdata);

  always_comb begin
    state_d    = state_q;
    lvl_d      = lvl_q;
    walk_start = 1'b0;
    l1_take    = 1'b0;
    l2_take    = 1'b0;
    fault_take = 1'b0;
    unique case (state_q)
      WS_IDLE: begin
        if (req_valid) begin
          walk_start = 1'b1;
          state_d    = WS_L1_REQ;
        end
      end
      WS_L1_REQ: if (mem_gnt) state_d = WS_L1_WAIT;
      WS_L1_WAIT: begin
        if (mem_rvalid) begin
          if (data_ok) begin
            l1_take = 1'b1;
            state_d = WS_L2_REQ;
          end else begin
            fault_take = 1'b1;
            lvl_d      = 1'b0;
            state_d    = WS_FAULT;
          end
        end
      end
      WS_L2_REQ: if (mem_gnt) state_d = WS_L2_WAIT;
      WS_L2_WAIT: begin
        if (mem_rvalid) begin
          if (data_ok) begin
            l2_take = 1'b1;
            state_d = WS_DONE;
          end else begin
            fault_take = 1'b1;
            lvl_d      = 1'b1;
            state_d    = WS_FAULT;
          end
        end
      end
      WS_DONE, WS_FAULT: if (rsp_ready) state_d = WS_IDLE;
      default: state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WS_IDLE;
      lvl_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      lvl_q   <= lvl_d;
    end
  end

  assign req_ready     = (state_q == WS_IDLE);
  assign mem_req       = (state_q == WS_L1_REQ) || (state_q == WS_L2_REQ);
  assign phase_l2      = (state_q == WS_L2_REQ);
  assign rsp_valid     = (state_q == WS_DONE) || (state_q == WS_FAULT);
  assign rsp_fault     = (state_q == WS_FAULT);
  assign rsp_fault_lvl = (state_q == WS_FAULT) && lvl_q;

endmodule

// File: rtl/pagewalk_dpath.sv
module pagewalk_dpath
  import pagewalk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     walk_start,
  input  logic     l1_take,
  input  logic     l2_take,
  input  logic     phase_l2,
  input  logic     fault_out,
  input  pw_addr_t sel_base,
  input  pw_addr_t req_vaddr,
  input  pw_addr_t mem_rdata,
  output pw_addr_t mem_rd_addr,
  output pw_addr_t rsp_paddr,
  output pw_addr_t cur_va
);

  pw_addr_t va_q, base_q, d1_q, pa_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q   <= '0;
      base_q <= '0;
      d1_q   <= '0;
      pa_q   <= '0;
    end else begin
      if (walk_start) begin
        va_q   <= req_vaddr;
        base_q <= sel_base;
      end
      if (l1_take) d1_q <= mem_rdata;
      if (l2_take) pa_q <= page_phys(mem_rdata, va_q);
    end
  end

  assign mem_rd_addr = phase_l2 ? l2_entry_addr(d1_q, va_q) : l1_entry_addr(base_q, va_q);
  assign rsp_paddr   = fault_out ? '0 : pa_q;
  assign cur_va      = va_q;

endmodule

// File: rtl/pagewalk_unit.sv
module pagewalk_unit
  import pagewalk_pkg::*;
#(
  parameter int unsigned NUM_BASE = 2,
  localparam int unsigned SEL_W = (NUM_BASE > 1) ? $clog2(NUM_BASE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_wr_en,
  input  logic [SEL_W-1:0] base_wr_sel,
  input  logic [31:0]      base_wr_data,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SEL_W-1:0] req_space,
  input  logic [31:0]      req_vaddr,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_fault,
  output logic             rsp_fault_lvl,
  output logic [31:0]      rsp_paddr,
  output logic             mem_req,
  input  logic             mem_gnt,
  output logic [31:0]      mem_rd_addr,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata
);

  pw_addr_t sel_base;
  pw_addr_t cur_va;
  logic     phase_l2;
  logic     walk_start;
  logic     l1_take;
  logic     l2_take;
  logic     fault_take;

  pagewalk_basebank #(.NUM_BASE(NUM_BASE)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (base_wr_en),
    .wr_sel  (base_wr_sel),
    .wr_data (base_wr_data),
    .rd_sel  (req_space),
    .rd_base (sel_base)
  );

  pagewalk_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_gnt       (mem_gnt),
    .mem_rvalid    (mem_rvalid),
    .mem_rdata     (mem_rdata),
    .mem_req       (mem_req),
    .phase_l2      (phase_l2),
    .rsp_ready     (rsp_ready),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .rsp_fault_lvl (rsp_fault_lvl),
    .walk_start    (walk_start),
    .l1_take       (l1_take),
    .l2_take       (l2_take),
    .fault_take    (fault_take)
  );

  pagewalk_dpath u_dpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .walk_start  (walk_start),
    .l1_take     (l1_take),
    .l2_take     (l2_take),
    .phase_l2    (phase_l2),
    .fault_out   (rsp_fault),
    .sel_base    (sel_base),
    .req_vaddr   (req_vaddr),
    .mem_rdata   (mem_rdata),
    .mem_rd_addr (mem_rd_addr),
    .rsp_paddr   (rsp_paddr),
    .cur_va      (cur_va)
  );

endmodule

// File: rtl/pagewalk_unit_chk.sv
module pagewalk_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_req,
  input logic        mem_gnt,
  input logic        mem_rvalid,
  input logic [31:0] mem_rd_addr,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic        rsp_fault,
  input logic        rsp_fault_lvl,
  input logic [31:0] rsp_paddr,
  input logic [31:0] cur_va,
  input logic        fault_take
);

  logic in_flight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                in_flight <= 1'b0;
    else if (mem_req && mem_gnt) in_flight <= 1'b1;
    else if (mem_rvalid)       in_flight <= 1'b0;
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_rd_addr)); // R8

  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    in_flight |-> !mem_req); // R8

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_fault_lvl)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid && !mem_req); // R9

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_paddr[11:0] == cur_va[11:0]); // R5

  AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    fault_take |=> !mem_req && rsp_valid && rsp_fault); // R6

endmodule

bind pagewalk_unit pagewalk_unit_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .mem_req       (mem_req),
  .mem_gnt       (mem_gnt),
  .mem_rvalid    (mem_rvalid),
  .mem_rd_addr   (mem_rd_addr),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_fault     (rsp_fault),
  .rsp_fault_lvl (rsp_fault_lvl),
  .rsp_paddr     (rsp_paddr),
  .cur_va        (cur_va),
  .fault_take    (fault_take)
);

// File: tb/pagewalk_unit_test.sv
module pagewalk_unit_test;

  localparam int CLK_PERIOD = 10;

  typedef struct { logic [31:0] addr; logic lvl; } fetch_t;
  typedef struct { logic fault; logic lvl; logic [31:0] pa; } rsp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_wr_en = 1'b0;
  logic        base_wr_sel = 1'b0;
  logic [31:0] base_wr_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_space = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic        rsp_fault;
  logic        rsp_fault_lvl;
  logic [31:0] rsp_paddr;
  logic        mem_req;
  logic        mem_gnt = 1'b0;
  logic [31:0] mem_rd_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  logic [31:0] table_mem [logic [31:0]];
  logic [31:0] shadow [2];
  fetch_t exp_fetch [$];
  rsp_t   exp_rsp [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pagewalk_unit uut (
    .clk(clk), .rst_n(rst_n),
    .base_wr_en(base_wr_en), .base_wr_sel(base_wr_sel), .base_wr_data(base_wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_space(req_space), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_fault_lvl(rsp_fault_lvl), .rsp_paddr(rsp_paddr),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_rd_addr(mem_rd_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return table_mem.exists(a) ? table_mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] l1_at(input logic [31:0] b, input logic [31:0] va);
    return (b / 32'd16384) * 32'd16384 + (va / 32'd1048576) * 32'd4;
  endfunction

  function automatic logic [31:0] l2_at(input logic [31:0] d1, input logic [31:0] va);
    return (d1 / 32'd1024) * 32'd1024 + ((va / 32'd4096) % 32'd256) * 32'd4;
  endfunction

  task automatic map(input logic [31:0] b, input logic [31:0] va, input logic [31:0] d1, input logic [31:0] d2);
    table_mem[l1_at(b, va)] = d1;
    table_mem[l2_at(d1, va)] = d2;
  endtask

  task automatic wr_base(input logic sel, input logic [31:0] val);
    @(negedge clk);
    base_wr_en = 1'b1; base_wr_sel = sel; base_wr_data = val;
    @(negedge clk);
    base_wr_en = 1'b0;
    shadow[sel] = val;
  endtask

  // driver: predicts fetches and the response, then issues the request
  task automatic walk(input logic sp, input logic [31:0] va, input bit midwr, input logic [31:0] nb);
    logic [31:0] a1, d1, a2, d2;
    fetch_t f;
    rsp_t r;
    while (exp_rsp.size() != 0 || exp_fetch.size() != 0 || !req_ready) @(negedge clk);
    a1 = l1_at(shadow[sp], va);
    d1 = rd(a1);
    f.addr = a1; f.lvl = 1'b0; exp_fetch.push_back(f);
    if (d1 % 4 == 0) begin
      r.fault = 1'b1; r.lvl = 1'b0; r.pa = '0;
    end else begin
      a2 = l2_at(d1, va);
      d2 = rd(a2);
      f.addr = a2; f.lvl = 1'b1; exp_fetch.push_back(f);
      if (d2 % 4 == 0) begin
        r.fault = 1'b1; r.lvl = 1'b1; r.pa = '0;
      end else begin
        r.fault = 1'b0; r.lvl = 1'b0; r.pa = (d2 / 32'd4096) * 32'd4096 + va % 32'd4096;
      end
    end
    exp_rsp.push_back(r);
    req_space = sp; req_vaddr = va; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9", {31'b0, req_ready}, 32'h0, "req_ready low during walk");
    if (midwr) wr_base(sp, nb); // R10: walk in flight keeps its base
  endtask

  // memory model: grants and returns entries, checks each fetch address
  initial begin
    int cnt = 0;
    logic [31:0] first_addr;
    fetch_t f;
    forever begin
      @(negedge clk);
      mem_gnt = 1'b0; mem_rvalid = 1'b0;
      if (mem_req) begin
        first_addr = mem_rd_addr;
        repeat (cnt % 3) @(negedge clk);
        chk("R8", mem_rd_addr, first_addr, "address held until grant");
        if (exp_fetch.size() == 0) begin
          n_chk++; n_err++;
          $display("FAIL R6 unexpected fetch actual %h expected none", mem_rd_addr);
        end else begin
          f = exp_fetch.pop_front();
          chk(f.lvl ? "R4" : "R3", mem_rd_addr, f.addr, "fetch address");
        end
        mem_gnt = 1'b1;
        @(negedge clk);
        mem_gnt = 1'b0;
        repeat (cnt % 2) begin
          @(negedge clk);
          chk("R8", {31'b0, mem_req}, 32'h0, "no request while read outstanding");
        end
        mem_rvalid = 1'b1; mem_rdata = rd(first_addr);
        @(negedge clk);
        mem_rvalid = 1'b0;
        cnt++;
      end
    end
  end

  // monitor: compares responses, stalls rsp_ready to test holding
  initial begin
    int stall = 1;
    int seen = 0;
    rsp_t e;
    forever begin
      @(negedge clk);
      if (rsp_valid && exp_rsp.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R9 unexpected response actual %h expected none", rsp_paddr);
        rsp_ready = 1'b1;
      end else if (rsp_valid) begin
        e = exp_rsp[0];
        chk(e.fault ? (e.lvl ? "R7" : "R6") : "R5", rsp_paddr, e.pa, "paddr");
        chk(e.fault ? (e.lvl ? "R7" : "R6") : "R5", {30'b0, rsp_fault, rsp_fault_lvl},
            {30'b0, e.fault, e.lvl}, "fault,lvl");
        if (stall > 0) begin
          rsp_ready = 1'b0;
          stall--;
        end else begin
          rsp_ready = 1'b1;
          void'(exp_rsp.pop_front());
          seen++;
          stall = seen % 3;
        end
      end else begin
        rsp_ready = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    shadow[0] = '0; shadow[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {31'b0, req_ready}, 32'h1, "req_ready after reset");
    chk("R1", {31'b0, rsp_valid}, 32'h0, "rsp_valid after reset");
    chk("R1", {31'b0, mem_req}, 32'h0, "mem_req after reset");

    wr_base(1'b0, 32'h0000_4000);
    wr_base(1'b1, 32'h0008_3FFF);   // R3: low 14 bits ignored
    map(32'h0000_4000, 32'h0000_1234, 32'h0010_0401, 32'h8765_4002);
    map(32'h0000_4000, 32'h0000_2ABC, 32'h0010_0401, 32'h1111_1003);
    map(32'h0000_4000, 32'hFFFF_FFFF, 32'h0020_03FD, 32'hABCD_EFFE);  // R4 low bits of d1
    map(32'h0008_0000, 32'h1230_0567, 32'h0030_0C01, 32'h0040_0002);
    map(32'h0008_0000, 32'h0000_1234, 32'h0060_0001, 32'h0700_0002);  // R2 same va other space
    map(32'h0000_C000, 32'h0000_1234, 32'h0050_0001, 32'h0600_0002);

    walk(1'b0, 32'h0000_1234, 0, '0);           // R5
    walk(1'b0, 32'h0000_2ABC, 0, '0);           // R4 shared L1 entry
    walk(1'b0, 32'hFFFF_FFFF, 0, '0);           // R3 R4 top indices
    walk(1'b1, 32'h1230_0567, 0, '0);           // R2
    walk(1'b1, 32'h0000_1234, 0, '0);           // R2
    walk(1'b0, 32'h0500_0000, 0, '0);           // R6
    walk(1'b0, 32'h0000_5000, 0, '0);           // R7
    walk(1'b0, 32'h0000_1234, 1, 32'h0000_C000); // R10
    walk(1'b0, 32'h0000_1234, 0, '0);           // R10 new base used
    walk(1'b1, 32'h0000_1234, 0, '0);           // R2 other register untouched

    while (exp_rsp.size() != 0 || exp_fetch.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    chk("R9", {31'b0, req_ready}, 32'h1, "idle at end");
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule